// File: doc/BRIEF.md
# Translation buffer read-by-index unit

This block keeps a small array of address-translation entries and serves one operation on it: given an index, it copies the selected entry into four architectural register images. These are a high-half image holding the virtual page-pair number, the invalidate flag and the address-space identifier; two low-half images, one for the even page and one for the odd page; and a page-size mask image. The read rebuilds each image from the stored fields. Address bits that fall inside the entry's page mask come back as zero. The single stored global bit appears in both low-half images. An entry marked invalid returns a fixed pattern when entry invalidation is enabled.

A read strobe is accepted on a rising clock edge. The four images are updated at that same edge, and a one-cycle completion pulse appears with them. A read can instead end with one of three results, and none of them changes any image. Coprocessor access may be disabled. The configured memory-management type may be one that cannot run the operation. The index may be past the end of the array, which sets a sticky error flag. A raw-field write port exists only to load the array for testing.

Top module: `tlb_idx_reader`

## Requirements
- R1: A read strobe sampled at a rising edge, with access enabled, a supported MMU type and an in-range index, loads entry_hi, entry_lo0, entry_lo1 and page_mask at that edge and raises rd_done for exactly that one following cycle.
- R2: When ie_level is nonzero and the selected entry carries its invalid flag, the read returns entry_hi = 32'h0000_0400 (only the invalidate flag at bit 10 set), entry_lo0 = entry_lo1 = 0 and page_mask = 0, the smallest page size.
- R3: When ie_level is zero, the invalid flag of an entry is ignored and its stored fields are returned as for a valid entry, with entry_hi bit 10 clear.
- R4: For a valid entry, entry_hi holds the masked page-pair number in bits 31:13, zeros in bits 12:11 and 9:8, zero in bit 10 and the 8-bit address-space identifier in bits 7:0.
- R5: For a valid entry, each low image holds zeros in bits 31:26, the masked 20-bit frame number in bits 25:6, and the page's 5-bit attribute word in bits 5:1. That word is the cache attribute in bits 4:2, dirty in bit 1 and valid in bit 0, so these land at image bits 5:3, 2 and 1. The global bit sits in bit 0. The even page goes to entry_lo0 and the odd page to entry_lo1.
- R6: Each set bit k of the 16-bit entry mask forces bit k of the page-pair number and bit k of both frame numbers to zero in the returned images.
- R7: The one global bit stored per entry is copied into bit 0 of both entry_lo0 and entry_lo1.
- R8: For a valid entry, page_mask holds the entry mask in bits 28:13 and zeros elsewhere.
- R9: A strobe with cp0_en low pulses exc_cop_unusable for one cycle instead of rd_done and leaves all four images unchanged. This result takes priority over R10 and R11.
- R10: A strobe with cp0_en high and mmu_type equal to 2 or 3 pulses exc_reserved for one cycle instead of rd_done and leaves all four images unchanged. This result takes priority over R11.
- R11: A strobe whose rd_index is 16 or more, when neither R9 nor R10 applies, leaves all images unchanged, produces no rd_done and sets idx_err. idx_err then stays set until reset.
- R12: Reset clears all four images, rd_done, both exception outputs and idx_err, and marks every array entry invalid with all fields zero.
- R13: Each accepted strobe produces exactly one of rd_done, exc_cop_unusable or exc_reserved, or only the idx_err update. None of the pulses appears without a strobe in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | input | 1 | Read strobe |
| rd_index | input | 6 | Index register value |
| cp0_en | input | 1 | Coprocessor access enabled |
| mmu_type | input | 3 | MMU type code; 2 and 3 reject the read |
| ie_level | input | 2 | Entry invalidation support level; nonzero means supported |
| wr_en | input | 1 | Test write strobe |
| wr_index | input | 4 | Test write entry number |
| wr_inv | input | 1 | Invalid flag for the written entry |
| wr_vpn2 | input | 19 | Page-pair number |
| wr_asid | input | 8 | Address-space identifier |
| wr_mask | input | 16 | Page mask field |
| wr_g | input | 1 | Global bit |
| wr_pfn0 | input | 20 | Even page frame number |
| wr_attr0 | input | 5 | Even page attributes {C[2:0], D, V} |
| wr_pfn1 | input | 20 | Odd page frame number |
| wr_attr1 | input | 5 | Odd page attributes {C[2:0], D, V} |
| entry_hi | output | 32 | High-half register image |
| entry_lo0 | output | 32 | Even page low register image |
| entry_lo1 | output | 32 | Odd page low register image |
| page_mask | output | 32 | Page mask register image |
| rd_done | output | 1 | One-cycle read completion pulse |
| exc_cop_unusable | output | 1 | One-cycle coprocessor-unusable pulse |
| exc_reserved | output | 1 | One-cycle reserved-operation pulse |
| idx_err | output | 1 | Sticky index-out-of-range flag |

## Verification
Several rules hold on every cycle, and the assertions check them there. At most one outcome pulse occurs, and every pulse has a strobe before it. The images do not change on either exception or on an out-of-range index, and idx_err is sticky. An invalid-entry read returns its fixed pattern. On a completed read, the zero gaps are in place, masked address bits come back as zero and the two global bits agree. What only the bench scenarios can show is that the images carry the right entry's values. That covers the field order, which frame goes to which low image, the effect of ie_level on an invalid entry, and the priority between the three reject causes.

// File: rtl/tlbr_pkg.sv
package tlbr_pkg;

  localparam int REG_W  = 32;
  localparam int VPN2_W = 19;
  localparam int ASID_W = 8;
  localparam int PFN_W  = 20;
  localparam int CA_W   = 3;
  localparam int ATTR_W = CA_W + 2;
  localparam int MASK_W = 16;

  // bit positions that software decodes
  localparam int HI_VPN_LSB = 13;
  localparam int HI_INV_BIT = 10;
  localparam int LO_PFN_LSB = 6;
  localparam int PM_LSB     = 13;

  typedef struct packed {
    logic              inv;
    logic [VPN2_W-1:0] vpn2;
    logic [ASID_W-1:0] asid;
    logic [MASK_W-1:0] mask;
    logic              g;
    logic [PFN_W-1:0]  pfn0;
    logic [ATTR_W-1:0] attr0;
    logic [PFN_W-1:0]  pfn1;
    logic [ATTR_W-1:0] attr1;
  } tlb_row_t;

  typedef enum logic [2:0] {
    RQ_IDLE,
    RQ_NOCOP,
    RQ_RSVD,
    RQ_RANGE,
    RQ_GO
  } rq_kind_t;

  function automatic tlb_row_t blank_row();
    tlb_row_t r;
    r     = '0;
    r.inv = 1'b1;
    return r;
  endfunction

  function automatic logic [VPN2_W-1:0] clip_vpn2(input logic [VPN2_W-1:0] v,
                                                  input logic [MASK_W-1:0] m);
    return v & ~{{(VPN2_W-MASK_W){1'b0}}, m};
  endfunction

  function automatic logic [PFN_W-1:0] clip_pfn(input logic [PFN_W-1:0] p,
                                                input logic [MASK_W-1:0] m);
    return p & ~{{(PFN_W-MASK_W){1'b0}}, m};
  endfunction

  function automatic logic [REG_W-1:0] build_hi(input logic [VPN2_W-1:0] vm,
                                                input logic [ASID_W-1:0] asid);
    return {vm, 2'b00, 1'b0, 2'b00, asid};
  endfunction

  function automatic logic [REG_W-1:0] build_lo(input logic [PFN_W-1:0] pm,
                                                input logic [ATTR_W-1:0] attr,
                                                input logic g);
    return {{(REG_W-PFN_W-ATTR_W-1){1'b0}}, pm, attr, g};
  endfunction

  function automatic logic [REG_W-1:0] build_pm(input logic [MASK_W-1:0] m);
    return {{(REG_W-MASK_W-PM_LSB){1'b0}}, m, {PM_LSB{1'b0}}};
  endfunction

  function automatic logic [REG_W-1:0] hi_inv_image();
    logic [REG_W-1:0] h;
    h             = '0;
    h[HI_INV_BIT] = 1'b1;
    return h;
  endfunction

endpackage

// File: rtl/tlbr_store.sv
module tlbr_store
  import tlbr_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  tlb_row_t         wr_row,
  input  logic [IDX_W-1:0] rd_idx,
  output tlb_row_t         rd_row
);

  tlb_row_t rows [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_row
    tlb_row_t row_q;
    logic     hit;

    assign hit = wr_en && (wr_idx == IDX_W'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   row_q <= blank_row();
      else if (hit) row_q <= wr_row;
    end

    assign rows[e] = row_q;
  end

  assign rd_row = rows[rd_idx];

endmodule

// File: rtl/tlbr_classify.sv
module tlbr_classify
  import tlbr_pkg::*;
#(
  parameter int ENTRIES  = 16,
  parameter int IDXREG_W = 6
) (
  input  logic                rd_req,
  input  logic [IDXREG_W-1:0] rd_index,
  input  logic                cp0_en,
  input  logic [2:0]          mmu_type,
  output rq_kind_t            kind,
  output logic                range_hit
);

  localparam logic [IDXREG_W-1:0] LIMIT = IDXREG_W'(ENTRIES);

  logic mmu_bad;

  assign mmu_bad   = (mmu_type == 3'd2) || (mmu_type == 3'd3);
  assign range_hit = rd_index >= LIMIT;

  always_comb begin
    kind = RQ_IDLE;
    if (rd_req) begin
      if (!cp0_en)        kind = RQ_NOCOP;
      else if (mmu_bad)   kind = RQ_RSVD;
      else if (range_hit) kind = RQ_RANGE;
      else                kind = RQ_GO;
    end
  end

endmodule

// File: rtl/tlbr_image.sv
module tlbr_image
  import tlbr_pkg::*;
(
  input  tlb_row_t         row,
  input  logic             ie_on,
  output logic [REG_W-1:0] img_hi,
  output logic [REG_W-1:0] img_lo0,
  output logic [REG_W-1:0] img_lo1,
  output logic [REG_W-1:0] img_pm,
  output logic             shows_inv
);

  logic [VPN2_W-1:0] vpn_m;
  logic [PFN_W-1:0]  pfn0_m;
  logic [PFN_W-1:0]  pfn1_m;

  assign shows_inv = ie_on && row.inv;
  assign vpn_m     = clip_vpn2(row.vpn2, row.mask);
  assign pfn0_m    = clip_pfn(row.pfn0, row.mask);
  assign pfn1_m    = clip_pfn(row.pfn1, row.mask);

  always_comb begin
    if (shows_inv) begin
      img_hi  = hi_inv_image();
      img_lo0 = '0;
      img_lo1 = '0;
      img_pm  = '0;
    end else begin
      img_hi  = build_hi(vpn_m, row.asid);
      img_lo0 = build_lo(pfn0_m, row.attr0, row.g);
      img_lo1 = build_lo(pfn1_m, row.attr1, row.g);
      img_pm  = build_pm(row.mask);
    end
  end

endmodule

// File: rtl/tlb_idx_reader.sv
module tlb_idx_reader
  import tlbr_pkg::*;
#(
  parameter int ENTRIES   = 16,
  parameter int IDXREG_W  = 6,
  localparam int IDX_W    = $clog2(ENTRIES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_req,
  input  logic [IDXREG_W-1:0] rd_index,
  input  logic                cp0_en,
  input  logic [2:0]          mmu_type,
  input  logic [1:0]          ie_level,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_index,
  input  logic                wr_inv,
  input  logic [VPN2_W-1:0]   wr_vpn2,
  input  logic [ASID_W-1:0]   wr_asid,
  input  logic [MASK_W-1:0]   wr_mask,
  input  logic                wr_g,
  input  logic [PFN_W-1:0]    wr_pfn0,
  input  logic [ATTR_W-1:0]   wr_attr0,
  input  logic [PFN_W-1:0]    wr_pfn1,
  input  logic [ATTR_W-1:0]   wr_attr1,
  output logic [REG_W-1:0]    entry_hi,
  output logic [REG_W-1:0]    entry_lo0,
  output logic [REG_W-1:0]    entry_lo1,
  output logic [REG_W-1:0]    page_mask,
  output logic                rd_done,
  output logic                exc_cop_unusable,
  output logic                exc_reserved,
  output logic                idx_err
);

  tlb_row_t         wr_row;
  tlb_row_t         sel_row;
  rq_kind_t         kind;
  logic             range_hit;
  logic             ie_on;
  logic             shows_inv;
  logic             load_fire;
  logic [REG_W-1:0] nx_hi, nx_lo0, nx_lo1, nx_pm;

  assign wr_row = '{inv:   wr_inv,   vpn2:  wr_vpn2, asid: wr_asid,
                    mask:  wr_mask,  g:     wr_g,
                    pfn0:  wr_pfn0,  attr0: wr_attr0,
                    pfn1:  wr_pfn1,  attr1: wr_attr1};

  assign ie_on     = ie_level != 2'd0;
  assign load_fire = kind == RQ_GO;

  tlbr_store #(.ENTRIES(ENTRIES)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_idx (wr_index),
    .wr_row (wr_row),
    .rd_idx (rd_index[IDX_W-1:0]),
    .rd_row (sel_row)
  );

  tlbr_classify #(.ENTRIES(ENTRIES), .IDXREG_W(IDXREG_W)) u_cls (
    .rd_req    (rd_req),
    .rd_index  (rd_index),
    .cp0_en    (cp0_en),
    .mmu_type  (mmu_type),
    .kind      (kind),
    .range_hit (range_hit)
  );

  tlbr_image u_img (
    .row       (sel_row),
    .ie_on     (ie_on),
    .img_hi    (nx_hi),
    .img_lo0   (nx_lo0),
    .img_lo1   (nx_lo1),
    .img_pm    (nx_pm),
    .shows_inv (shows_inv)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entry_hi         <= '0;
      entry_lo0        <= '0;
      entry_lo1        <= '0;
      page_mask        <= '0;
      rd_done          <= 1'b0;
      exc_cop_unusable <= 1'b0;
      exc_reserved     <= 1'b0;
      idx_err          <= 1'b0;
    end else begin
      rd_done          <= 1'b0;
      exc_cop_unusable <= 1'b0;
      exc_reserved     <= 1'b0;
      unique case (kind)
        RQ_NOCOP: exc_cop_unusable <= 1'b1;
        RQ_RSVD:  exc_reserved     <= 1'b1;
        RQ_RANGE: idx_err          <= 1'b1;
        RQ_GO: begin
          rd_done   <= 1'b1;
          entry_hi  <= nx_hi;
          entry_lo0 <= nx_lo0;
          entry_lo1 <= nx_lo1;
          page_mask <= nx_pm;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/tlbr_checker.sv
module tlbr_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_req,
  input logic        range_hit,
  input logic        cp0_en,
  input logic [2:0]  mmu_type,
  input logic [31:0] entry_hi,
  input logic [31:0] entry_lo0,
  input logic [31:0] entry_lo1,
  input logic [31:0] page_mask,
  input logic        rd_done,
  input logic        exc_cop_unusable,
  input logic        exc_reserved,
  input logic        idx_err
);

  logic any_pulse;
  logic imgs_stable;
  assign any_pulse = rd_done || exc_cop_unusable || exc_reserved;

  a_r13_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_done, exc_cop_unusable, exc_reserved}));

  a_r13_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    any_pulse |-> $past(rd_req));

  a_r9_nocop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    exc_cop_unusable |-> ($stable(entry_hi) && $stable(entry_lo0) &&
                          $stable(entry_lo1) && $stable(page_mask)));

  a_r10_rsvd_holds: assert property (@(posedge clk) disable iff (!rst_n)
    exc_reserved |-> ($stable(entry_hi) && $stable(entry_lo0) &&
                      $stable(entry_lo1) && $stable(page_mask)));

  a_r11_range_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && cp0_en && mmu_type != 3'd2 && mmu_type != 3'd3 && range_hit)
      |=> (!rd_done && idx_err && $stable(entry_hi) && $stable(entry_lo0) &&
           $stable(entry_lo1) && $stable(page_mask)));

  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    idx_err |=> idx_err);

  a_r2_inv_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && entry_hi[10]) |-> (entry_hi == 32'h0000_0400 && entry_lo0 == '0 &&
                                   entry_lo1 == '0 && page_mask == '0));

  a_r7_shared_g: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && !entry_hi[10]) |-> (entry_lo0[0] == entry_lo1[0]));

  a_r6_masked_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> ((entry_hi[28:13] & page_mask[28:13]) == '0 &&
                 (entry_lo0[21:6] & page_mask[28:13]) == '0 &&
                 (entry_lo1[21:6] & page_mask[28:13]) == '0));

  a_r4_hi_gaps: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> (entry_hi[12:11] == 2'b00 && entry_hi[9:8] == 2'b00));

  a_r5_lo_fill: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> (entry_lo0[31:26] == '0 && entry_lo1[31:26] == '0));

  a_r8_pm_shape: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> (page_mask[31:29] == '0 && page_mask[12:0] == '0));

endmodule

bind tlb_idx_reader tlbr_checker u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .rd_req           (rd_req),
  .range_hit        (range_hit),
  .cp0_en           (cp0_en),
  .mmu_type         (mmu_type),
  .entry_hi         (entry_hi),
  .entry_lo0        (entry_lo0),
  .entry_lo1        (entry_lo1),
  .page_mask        (page_mask),
  .rd_done          (rd_done),
  .exc_cop_unusable (exc_cop_unusable),
  .exc_reserved     (exc_reserved),
  .idx_err          (idx_err)
);

// File: tb/sim_tlb_idx_reader.sv
`timescale 1ns/1ps
module sim_tlb_idx_reader;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_req = 1'b0;
  logic [5:0]  rd_index = '0;
  logic        cp0_en = 1'b1;
  logic [2:0]  mmu_type = 3'd1;
  logic [1:0]  ie_level = 2'd1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_index = '0;
  logic        wr_inv = 1'b0;
  logic [18:0] wr_vpn2 = '0;
  logic [7:0]  wr_asid = '0;
  logic [15:0] wr_mask = '0;
  logic        wr_g = 1'b0;
  logic [19:0] wr_pfn0 = '0;
  logic [4:0]  wr_attr0 = '0;
  logic [19:0] wr_pfn1 = '0;
  logic [4:0]  wr_attr1 = '0;
  logic [31:0] entry_hi, entry_lo0, entry_lo1, page_mask;
  logic        rd_done, exc_cop_unusable, exc_reserved, idx_err;

  int n_chk = 0;
  int n_bad = 0;

  // shadow of what was written
  logic        s_inv  [16];
  logic [18:0] s_vpn  [16];
  logic [7:0]  s_asid [16];
  logic [15:0] s_mask [16];
  logic        s_g    [16];
  logic [19:0] s_p0   [16];
  logic [4:0]  s_a0   [16];
  logic [19:0] s_p1   [16];
  logic [4:0]  s_a1   [16];

  always #5 clk = ~clk;

  tlb_idx_reader u0 (.*);

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] e_hi(input int i);
    logic [31:0] v, m;
    v = 32'(s_vpn[i]) << 13;
    m = 32'(s_mask[i]) << 13;
    return (v & ~m) | 32'(s_asid[i]);
  endfunction

  function automatic logic [31:0] e_lo(input int i, input bit odd);
    logic [31:0] p, m;
    p = (odd ? 32'(s_p1[i]) : 32'(s_p0[i])) << 6;
    m = 32'(s_mask[i]) << 6;
    return (p & ~m) | ((odd ? 32'(s_a1[i]) : 32'(s_a0[i])) << 1) | 32'(s_g[i]);
  endfunction

  task automatic put(input int i, input logic inv, input logic [18:0] vpn,
                     input logic [7:0] asid, input logic [15:0] mask, input logic g,
                     input logic [19:0] p0, input logic [4:0] a0,
                     input logic [19:0] p1, input logic [4:0] a1);
    @(negedge clk);
    wr_en = 1'b1; wr_index = 4'(i); wr_inv = inv; wr_vpn2 = vpn; wr_asid = asid;
    wr_mask = mask; wr_g = g; wr_pfn0 = p0; wr_attr0 = a0; wr_pfn1 = p1; wr_attr1 = a1;
    s_inv[i] = inv; s_vpn[i] = vpn; s_asid[i] = asid; s_mask[i] = mask; s_g[i] = g;
    s_p0[i] = p0; s_a0[i] = a0; s_p1[i] = p1; s_a1[i] = a1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // strobe for one edge; outputs are sampled at the following falling edge
  task automatic strobe(input logic [5:0] idx);
    @(negedge clk);
    rd_req = 1'b1; rd_index = idx;
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic expect_entry(input string req, input int i);
    check({req, " done"}, 32'(rd_done), 32'd1);
    check({req, " hi"},   entry_hi,  e_hi(i));
    check({req, " lo0"},  entry_lo0, e_lo(i, 1'b0));
    check({req, " lo1"},  entry_lo1, e_lo(i, 1'b1));
    check({req, " pm"},   page_mask, 32'(s_mask[i]) << 13);
  endtask

  task automatic expect_held(input string req, input logic [31:0] h, input logic [31:0] l0,
                             input logic [31:0] l1, input logic [31:0] pm);
    check({req, " hi held"},  entry_hi,  h);
    check({req, " lo0 held"}, entry_lo0, l0);
    check({req, " lo1 held"}, entry_lo1, l1);
    check({req, " pm held"},  page_mask, pm);
    check({req, " no done"},  32'(rd_done), 32'd0);
  endtask

  task automatic t_reset();
    check("R12 hi",  entry_hi,  '0);
    check("R12 lo0", entry_lo0, '0);
    check("R12 lo1", entry_lo1, '0);
    check("R12 pm",  page_mask, '0);
    check("R12 flags", {28'd0, rd_done, exc_cop_unusable, exc_reserved, idx_err}, '0);
    strobe(6'd5);
    check("R12 entry invalid after reset", entry_hi, 32'h0000_0400);
    check("R12 lo0 of invalid", entry_lo0, '0);
  endtask

  task automatic t_fields();
    put(0,  1'b0, 19'h7_1234, 8'hA5, 16'h0, 1'b1, 20'hF_0F0F, 5'b101_1_1, 20'h1_2345, 5'b011_0_1);
    put(3,  1'b0, 19'h2_AAAA, 8'h3C, 16'h0, 1'b0, 20'h8_0001, 5'b010_1_0, 20'h7_FFFF, 5'b111_1_1);
    put(15, 1'b0, 19'h5_5555, 8'hFF, 16'h0, 1'b1, 20'h0_0000, 5'b000_0_0, 20'hF_FFFF, 5'b001_0_0);
    strobe(6'd0);  expect_entry("R1 R4 R5 R7 e0", 0);
    strobe(6'd3);  expect_entry("R1 R4 R5 R7 e3", 3);
    strobe(6'd15); expect_entry("R1 R4 R5 R7 e15", 15);
    @(negedge clk);
    check("R1 R13 done lasts one cycle", 32'(rd_done), 32'd0);
  endtask

  task automatic t_mask();
    put(7, 1'b0, 19'h7_FFFF, 8'h11, 16'h00FF, 1'b1, 20'hF_FFFF, 5'b100_1_1, 20'hA_BCDE, 5'b000_1_0);
    strobe(6'd7);
    expect_entry("R6 R8 mask 00FF", 7);
    check("R6 hi literal", entry_hi, 32'hFFE0_0011);
    put(8, 1'b0, 19'h7_FFFF, 8'h00, 16'hFFFF, 1'b0, 20'hF_FFFF, 5'b0, 20'hF_FFFF, 5'b0);
    strobe(6'd8);
    expect_entry("R6 R8 mask FFFF", 8);
    check("R8 pm literal", page_mask, 32'h1FFF_E000);
  endtask

  task automatic t_invalid();
    put(9, 1'b1, 19'h1_2345, 8'h77, 16'h000F, 1'b1, 20'h1_1111, 5'b111_1_1, 20'h2_2222, 5'b010_1_1);
    ie_level = 2'd2;
    strobe(6'd9);
    check("R2 done",  32'(rd_done), 32'd1);
    check("R2 hi",    entry_hi,  32'h0000_0400);
    check("R2 lo0",   entry_lo0, '0);
    check("R2 lo1",   entry_lo1, '0);
    check("R2 pm",    page_mask, '0);
    ie_level = 2'd0;
    strobe(6'd9);
    expect_entry("R3 invalid ignored", 9);
    ie_level = 2'd1;
  endtask

  task automatic t_reject();
    logic [31:0] h, l0, l1, pm;
    strobe(6'd3);
    h = entry_hi; l0 = entry_lo0; l1 = entry_lo1; pm = page_mask;
    cp0_en = 1'b0; mmu_type = 3'd2;
    strobe(6'd7);
    check("R9 cop pulse", 32'(exc_cop_unusable), 32'd1);
    check("R9 over R10",  32'(exc_reserved), 32'd0);
    expect_held("R9", h, l0, l1, pm);
    @(negedge clk);
    check("R9 R13 pulse one cycle", 32'(exc_cop_unusable), 32'd0);
    cp0_en = 1'b1;
    strobe(6'd20);
    check("R10 rsvd type 2", 32'(exc_reserved), 32'd1);
    check("R10 over R11", 32'(idx_err), 32'd0);
    expect_held("R10", h, l0, l1, pm);
    mmu_type = 3'd3;
    strobe(6'd7);
    check("R10 rsvd type 3", 32'(exc_reserved), 32'd1);
    expect_held("R10 t3", h, l0, l1, pm);
    mmu_type = 3'd0;
    strobe(6'd16);
    check("R11 err set", 32'(idx_err), 32'd1);
    check("R11 no exc", {30'd0, exc_cop_unusable, exc_reserved}, '0);
    expect_held("R11", h, l0, l1, pm);
    strobe(6'd63);
    expect_held("R11 idx63", h, l0, l1, pm);
    strobe(6'd0);
    expect_entry("R11 read after err", 0);
    check("R11 sticky", 32'(idx_err), 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fields();
    t_mask();
    t_invalid();
    t_reject();
    repeat (2) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule